// File: doc/BRIEF.md
# Power-Fail Protected Byte-Wide Memory Front End

This block is the clocked front end of a 2 MiB byte-wide memory that must keep its contents across supply loss. On the host side it accepts an asynchronous SRAM-style port: active-low chip enable, write enable and output enable, a 21-bit address and an 8-bit data bus. The data bus is split into input, output and output-enable lines. On the memory side it drives four banks of 512K x 8. The two most significant address bits choose the bank and the low 19 bits go to that bank. All host strobes, the buses and the two supply flags pass through two-flop synchronisers. Every cycle decision is then taken on edges of the synchronised copies.

A write starts when the second of chip enable and write enable goes low. It ends when the first of them goes high. Exactly one bank write strobe is issued when the write ends, and only if the cycle was clean: it started after the write-enable recovery window, the address and data held still, and the supply stayed good throughout. An external comparator supplies two digital flags, supply-fail and supply-good. Once the fail flag is seen, the port is frozen: outputs float and no write takes effect. Normal operation returns only when the supply-good flag is present. The fail flag merely dropping is not enough.

Top module: `nvfe_front`

## Requirements
- R1: With chip enable low, write enable high, output enable low and supply good, `host_dq_oe` is 1 and `host_dq_o` carries the byte stored at `host_addr`. The bus is settled within 6 clock cycles of the host inputs becoming stable.
- R2: A bank write strobe `bank_we` is one-hot, and its set bit index equals address bits [20:19] of the write (00 selects bank 0, 11 selects bank 3). `bank_addr` carries address bits [18:0] and `bank_wdata` carries the data byte.
- R3: A write cycle spans the interval in which both chip enable and write enable are low. Each completed cycle gives exactly one single-cycle `bank_we` pulse, issued after its end. This holds both when write enable bounds the cycle and when chip enable bounds it.
- R4: If write enable falls while chip enable and output enable are low, `host_dq_oe` drops to 0 within 4 cycles.
- R5: A write cycle whose start falls within `REC_CYC` cycles (default 4) after write enable rises is ignored. It gives no strobe and the target byte keeps its old value.
- R6: While `pwr_fail` is 1, `host_dq_oe` is 0 and host writes have no effect on memory.
- R7: After `pwr_fail` returns to 0, the port stays write-protected with outputs off until `pwr_good` is 1.
- R8: A write cycle during which `pwr_fail` asserts gives no strobe, even if the supply is good again before the cycle ends. The target byte keeps its old value.
- R9: If the address or data changes during a write cycle, `proto_err` pulses once at the end of that cycle, no strobe is issued, and the byte keeps its old value.
- R10: During reset, `host_dq_oe`, `bank_we` and `proto_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ce_n | input | 1 | Host chip enable, active low, asynchronous |
| host_we_n | input | 1 | Host write enable, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_addr | input | 21 | Host byte address |
| host_dq_i | input | 8 | Host write data |
| host_dq_o | output | 8 | Read data toward the host |
| host_dq_oe | output | 1 | Drive enable for the host data bus |
| pwr_fail | input | 1 | Supply below fail threshold |
| pwr_good | input | 1 | Supply fully good |
| bank_rdata | input | 32 | Read bytes of the four banks, bank n at bits [8n+7:8n] |
| bank_addr | output | 19 | Address within the bank |
| bank_wdata | output | 8 | Write byte to the banks |
| bank_we | output | 4 | One-hot bank write strobe |
| proto_err | output | 1 | Pulse: write dropped because the address or data moved |

## Verification
The supply-fail freeze and the termination of a write can both land in one cycle. In that case the end-of-cycle decision must favour the freeze. The bench provokes this by raising the fail flag while a write holds both strobes low, then restoring the supply before the strobes are released. It judges the result by the absence of any bank strobe and by reading back the unchanged byte. A second overlap pairs the output-disable path with the start of a write: write enable falls during an active read. The bench checks that the bus drive drops, and that the resulting write still lands exactly once.

// File: rtl/nvfe_pkg.sv
// Package: shared sizing for the power-fail protected memory front end.
// Assumes a power-of-two bank count; all widths derive from these values.
package nvfe_pkg;
    localparam int ADDR_W_DEF  = 21;
    localparam int DATA_W_DEF  = 8;
    localparam int BANKS_DEF   = 4;
    localparam int REC_CYC_DEF = 4;
    localparam int SYNC_DEF    = 2;
endpackage

// File: rtl/nvfe_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes bus members are quasi-static while they are sampled; each bit is
// resynchronised independently with the given reset value.
module nvfe_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the bundle one stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/nvfe_pwr_guard.sv
// Module: supply guard. Holds the port in protection from the moment the
// fail flag is seen until the fully-good flag is present with fail clear.
// Assumes synchronised flags; protection is the reset state.
module nvfe_pwr_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_s,
    input  logic good_s,
    output logic pwr_ok
);
    logic prot_q;

    // Purpose: sticky protection flag, set on fail, cleared only on good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b1;
        end else if (fail_s) begin
            prot_q <= 1'b1;
        end else if (good_s) begin
            prot_q <= 1'b0;
        end
    end

    assign pwr_ok = ~prot_q & ~fail_s;
endmodule

// File: rtl/nvfe_wr_track.sv
// Module: write cycle tracker. A cycle is active while both chip enable and
// write enable are low (so the later fall opens it and the earlier rise
// closes it). Latches address and data at the start, watches them for
// change, enforces the write-enable recovery window and aborts on power loss.
// Assumes synchronised strobes and buses.
module nvfe_wr_track #(
    parameter int ADDR_W  = 21,
    parameter int DATA_W  = 8,
    parameter int REC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              pwr_ok,
    output logic              wr_fire,
    output logic              wr_err,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int RC_W = $clog2(REC_CYC + 1) + 1;

    logic            act, act_prev, we_prev;
    logic            start, finish, clean;
    logic            armed_q, aborted_q, changed_q;
    logic [RC_W-1:0] rec_cnt;

    assign act    = ~ce_s & ~we_s;
    assign start  = act & ~act_prev;
    assign finish = ~act & act_prev;

    // Purpose: edge history of the cycle and of write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_prev <= 1'b0;
            we_prev  <= 1'b1;
        end else begin
            act_prev <= act;
            we_prev  <= we_s;
        end
    end

    // Purpose: recovery counter reloaded on every write-enable rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt <= '0;
        end else if (we_s && !we_prev) begin
            rec_cnt <= RC_W'(REC_CYC);
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
        end
    end

    // Purpose: latch the cycle's target and track its validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            aborted_q <= 1'b0;
            changed_q <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else if (start) begin
            armed_q   <= pwr_ok && (rec_cnt == '0);
            aborted_q <= 1'b0;
            changed_q <= 1'b0;
            wr_addr   <= addr_s;
            wr_data   <= data_s;
        end else if (act) begin
            if (!pwr_ok) begin
                aborted_q <= 1'b1;
            end
            if (addr_s != wr_addr || data_s != wr_data) begin
                changed_q <= 1'b1;
            end
        end else if (finish) begin
            armed_q <= 1'b0;
        end
    end

    assign clean   = finish & armed_q & ~aborted_q & pwr_ok;
    assign wr_fire = clean & ~changed_q;
    assign wr_err  = clean & changed_q;
endmodule

// File: rtl/nvfe_bank_port.sv
// Module: bank side of the front end. Decodes the bank from the top address
// bits, registers the bank strobe, address and data, and returns the
// selected read byte and bus enable to the host.
// Assumes bank read data is combinational on bank_addr.
module nvfe_bank_port #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8,
    parameter int BANKS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_ok,
    input  logic                    ce_s,
    input  logic                    oe_s,
    input  logic                    we_s,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    wr_fire,
    input  logic                    wr_err,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [BANKS*DATA_W-1:0] bank_rdata,
    output logic [ADDR_W-$clog2(BANKS)-1:0] bank_addr,
    output logic [DATA_W-1:0]       bank_wdata,
    output logic [BANKS-1:0]        bank_we,
    output logic                    proto_err,
    output logic [DATA_W-1:0]       dq_o,
    output logic                    dq_oe
);
    localparam int SEL_W   = $clog2(BANKS);
    localparam int BANK_AW = ADDR_W - SEL_W;

    logic [BANKS-1:0]  wr_dec;
    logic [SEL_W-1:0]  rd_bank_q;
    logic [DATA_W-1:0] rd_mux;

    generate
        for (genvar g = 0; g < BANKS; g++) begin : g_dec
            assign wr_dec[g] = (wr_addr[ADDR_W-1 -: SEL_W] == SEL_W'(g));
        end
    endgenerate

    // Purpose: pick the read byte of the bank addressed last cycle.
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (rd_bank_q == SEL_W'(b)) begin
                rd_mux = bank_rdata[b*DATA_W +: DATA_W];
            end
        end
    end

    // Purpose: bank address, strobe and write data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_addr  <= '0;
            bank_wdata <= '0;
            bank_we    <= '0;
            rd_bank_q  <= '0;
        end else if (wr_fire) begin
            bank_addr  <= wr_addr[BANK_AW-1:0];
            bank_wdata <= wr_data;
            bank_we    <= wr_dec;
        end else begin
            bank_addr  <= rd_addr[BANK_AW-1:0];
            bank_we    <= '0;
            rd_bank_q  <= rd_addr[ADDR_W-1 -: SEL_W];
        end
    end

    // Purpose: host read data, bus enable and protocol error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_o      <= '0;
            dq_oe     <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            dq_o      <= rd_mux;
            dq_oe     <= pwr_ok & ~ce_s & ~oe_s & we_s;
            proto_err <= wr_err;
        end
    end
endmodule

// File: rtl/nvfe_front.sv
// Module: top of the power-fail protected memory front end. Synchronises
// the host port and supply flags, tracks write cycles and drives four banks.
// Assumes host address and data are stable while a strobe edge is resolved.
module nvfe_front #(
    parameter int ADDR_W      = nvfe_pkg::ADDR_W_DEF,
    parameter int DATA_W      = nvfe_pkg::DATA_W_DEF,
    parameter int BANK_CNT    = nvfe_pkg::BANKS_DEF,
    parameter int REC_CYC     = nvfe_pkg::REC_CYC_DEF,
    parameter int SYNC_STAGES = nvfe_pkg::SYNC_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_ce_n,
    input  logic                       host_we_n,
    input  logic                       host_oe_n,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_dq_i,
    output logic [DATA_W-1:0]          host_dq_o,
    output logic                       host_dq_oe,
    input  logic                       pwr_fail,
    input  logic                       pwr_good,
    input  logic [BANK_CNT*DATA_W-1:0] bank_rdata,
    output logic [ADDR_W-$clog2(BANK_CNT)-1:0] bank_addr,
    output logic [DATA_W-1:0]          bank_wdata,
    output logic [BANK_CNT-1:0]        bank_we,
    output logic                       proto_err
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic              ce_s, we_s, oe_s;
    logic              fail_s, good_s, pwr_ok;
    logic [ADDR_W-1:0] addr_s, wr_addr;
    logic [DATA_W-1:0] data_s, wr_data;
    logic              wr_fire, wr_err;

    nvfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strb_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({host_ce_n, host_we_n, host_oe_n}),
        .q_sync({ce_s, we_s, oe_s})
    );

    nvfe_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({host_addr, host_dq_i}),
        .q_sync({addr_s, data_s})
    );

    nvfe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_pwr_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({pwr_fail, pwr_good}),
        .q_sync({fail_s, good_s})
    );

    nvfe_pwr_guard u_guard (
        .clk(clk), .rst_n(rst_n),
        .fail_s(fail_s), .good_s(good_s), .pwr_ok(pwr_ok)
    );

    nvfe_wr_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REC_CYC(REC_CYC)) u_track (
        .clk(clk), .rst_n(rst_n),
        .ce_s(ce_s), .we_s(we_s), .addr_s(addr_s), .data_s(data_s),
        .pwr_ok(pwr_ok),
        .wr_fire(wr_fire), .wr_err(wr_err),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    nvfe_bank_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANK_CNT)) u_port (
        .clk(clk), .rst_n(rst_n),
        .pwr_ok(pwr_ok), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
        .rd_addr(addr_s),
        .wr_fire(wr_fire), .wr_err(wr_err),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .bank_rdata(bank_rdata),
        .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_we(bank_we),
        .proto_err(proto_err),
        .dq_o(host_dq_o), .dq_oe(host_dq_oe)
    );
endmodule

// File: rtl/nvfe_checker.sv
// Module: property checker for nvfe_front, attached by bind below.
// Assumes the internal supply verdict and synchronised write enable.
module nvfe_checker #(
    parameter int BANKS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_ok,
    input logic             we_s,
    input logic [BANKS-1:0] bank_we,
    input logic             proto_err,
    input logic             host_dq_oe
);
    // R2: at most one bank strobe at a time
    p_we_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R3: a strobe lasts a single cycle
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we != '0) |=> (bank_we == '0));

    // R4: the bus is only driven when write enable was high
    p_oe_we_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_dq_oe |-> $past(we_s));

    // R6: no bus drive after an unsafe supply verdict
    p_oe_off_unsafe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_ok) |-> !host_dq_oe);

    // R7: no bank strobe after an unsafe supply verdict
    p_no_we_unsafe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_ok) |-> (bank_we == '0));

    // R9: a protocol error never comes with a strobe
    p_err_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (bank_we == '0));
endmodule

bind nvfe_front nvfe_checker #(.BANKS(BANK_CNT)) u_nvfe_chk (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .we_s(we_s),
    .bank_we(bank_we), .proto_err(proto_err), .host_dq_oe(host_dq_oe)
);

// File: tb/tb_nvfe_front.sv
// Bench for nvfe_front: behavioural banks (256 bytes each, indexed by the
// low address byte), a vector table of writes walked by one loop, then
// directed tests for reset, recovery, power loss and protocol errors.
module tb_nvfe_front;
    localparam int REC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
    logic [20:0] host_addr = '0;
    logic [7:0]  host_dq_i = '0;
    logic [7:0]  host_dq_o;
    logic        host_dq_oe;
    logic        pwr_fail = 1'b0, pwr_good = 1'b1;
    logic [31:0] bank_rdata;
    logic [18:0] bank_addr;
    logic [7:0]  bank_wdata;
    logic [3:0]  bank_we;
    logic        proto_err;

    logic [7:0] mem [4][256];
    logic [7:0] ref_mem [4][256];
    int checks = 0, errors = 0;
    int we_pulses = 0, err_pulses = 0;
    logic [3:0] last_we = '0;
    bit done = 0;

    always #5 clk = ~clk;

    nvfe_front #(.REC_CYC(REC)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .host_addr(host_addr), .host_dq_i(host_dq_i),
        .host_dq_o(host_dq_o), .host_dq_oe(host_dq_oe),
        .pwr_fail(pwr_fail), .pwr_good(pwr_good),
        .bank_rdata(bank_rdata), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_we(bank_we), .proto_err(proto_err)
    );

    function automatic logic [7:0] init_val(int b, int i);
        return 8'(b * 37 + i * 3 + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++)
                for (int i = 0; i < 256; i++) mem[b][i] <= init_val(b, i);
        end else begin
            for (int b = 0; b < 4; b++)
                if (bank_we[b]) mem[b][bank_addr[7:0]] <= bank_wdata;
        end
    end

    generate
        for (genvar g = 0; g < 4; g++) begin : g_rd
            assign bank_rdata[g*8 +: 8] = mem[g][bank_addr[7:0]];
        end
    endgenerate

    always @(negedge clk) begin
        if (bank_we != 4'b0) begin
            we_pulses <= we_pulses + 1;
            last_we   <= bank_we;
        end
        if (proto_err) err_pulses <= err_pulses + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [20:0] a, input logic [7:0] d, input bit ce_ctrl);
        @(negedge clk);
        host_addr = a; host_dq_i = d; host_oe_n = 1'b1;
        @(negedge clk);
        if (ce_ctrl) begin host_we_n = 1'b0; @(negedge clk); host_ce_n = 1'b0; end
        else begin host_ce_n = 1'b0; @(negedge clk); host_we_n = 1'b0; end
        repeat (4) @(negedge clk);
        if (ce_ctrl) begin host_ce_n = 1'b1; @(negedge clk); host_we_n = 1'b1; end
        else begin host_we_n = 1'b1; @(negedge clk); host_ce_n = 1'b1; end
        repeat (REC + 8) @(negedge clk);
    endtask

    task automatic do_read(input logic [20:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        host_addr = a; host_ce_n = 1'b0; host_we_n = 1'b1; host_oe_n = 1'b0;
        repeat (6) @(negedge clk);
        d = host_dq_o; oe = host_dq_oe;
        host_ce_n = 1'b1; host_oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // {ce_ctrl, addr[20:0], data[7:0]}
    localparam logic [29:0] VEC [8] = '{
        {1'b0, 21'h000012, 8'hA1},
        {1'b1, 21'h080034, 8'hB2},
        {1'b0, 21'h100056, 8'hC3},
        {1'b1, 21'h180078, 8'hD4},
        {1'b1, 21'h0001F0, 8'h00},
        {1'b0, 21'h0FFFE1, 8'hFF},
        {1'b1, 21'h17FFC2, 8'h5A},
        {1'b0, 21'h1FFFFF, 8'h3C}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        int         p0, e0;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 256; i++) ref_mem[b][i] = init_val(b, i);

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 dq_oe", 32'(host_dq_oe), 0);
        chk("R10 bank_we", 32'(bank_we), 0);
        chk("R10 proto_err", 32'(proto_err), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1, R2, R3: table of writes with read-back
        for (int v = 0; v < 8; v++) begin
            logic [20:0] a;
            logic [7:0]  d;
            a = VEC[v][28:8]; d = VEC[v][7:0];
            p0 = we_pulses;
            do_write(a, d, VEC[v][29]);
            chk("R3 one strobe per write", 32'(we_pulses - p0), 1);
            chk("R2 bank decode", 32'(last_we), 32'(4'b1 << a[20:19]));
            ref_mem[a[20:19]][a[7:0]] = d;
            do_read(a, rd, oe);
            chk("R1 read drive", 32'(oe), 1);
            chk("R1 read data", 32'(rd), 32'(ref_mem[a[20:19]][a[7:0]]));
        end

        // R4: write enable falling during an active read drops the drive
        @(negedge clk);
        host_addr = 21'h100090; host_dq_i = 8'h77;
        host_ce_n = 1'b0; host_we_n = 1'b1; host_oe_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4 drive before", 32'(host_dq_oe), 1);
        p0 = we_pulses;
        host_we_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 drive off", 32'(host_dq_oe), 0);
        host_we_n = 1'b1;
        @(negedge clk); host_ce_n = 1'b1; host_oe_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        chk("R4 write landed once", 32'(we_pulses - p0), 1);
        ref_mem[2][8'h90] = 8'h77;

        // R5: a cycle started inside the recovery window is ignored
        @(negedge clk);
        p0 = we_pulses;
        host_addr = 21'h0000A0; host_dq_i = 8'h11; host_oe_n = 1'b1;
        @(negedge clk); host_ce_n = 1'b0;
        @(negedge clk); host_we_n = 1'b0;
        repeat (4) @(negedge clk);
        host_we_n = 1'b1; host_addr = 21'h0000A1; host_dq_i = 8'h22;
        @(negedge clk); host_we_n = 1'b0;
        repeat (4) @(negedge clk);
        host_we_n = 1'b1;
        @(negedge clk); host_ce_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        chk("R5 only first write", 32'(we_pulses - p0), 1);
        ref_mem[0][8'hA0] = 8'h11;
        do_read(21'h0000A1, rd, oe);
        chk("R5 early byte unchanged", 32'(rd), 32'(ref_mem[0][8'hA1]));
        do_read(21'h0000A0, rd, oe);
        chk("R5 first byte written", 32'(rd), 32'h11);

        // R6: supply fail freezes the port
        pwr_fail = 1'b1; pwr_good = 1'b0;
        repeat (6) @(negedge clk);
        p0 = we_pulses;
        do_write(21'h080011, 8'hEE, 1'b0);
        chk("R6 no strobe", 32'(we_pulses - p0), 0);
        do_read(21'h080011, rd, oe);
        chk("R6 bus floats", 32'(oe), 0);

        // R7: fail clear but not yet good stays protected
        pwr_fail = 1'b0;
        repeat (6) @(negedge clk);
        do_write(21'h080011, 8'hDD, 1'b1);
        chk("R7 no strobe in band", 32'(we_pulses - p0), 0);
        do_read(21'h080011, rd, oe);
        chk("R7 bus floats in band", 32'(oe), 0);
        pwr_good = 1'b1;
        repeat (6) @(negedge clk);
        do_read(21'h080011, rd, oe);
        chk("R7 drive after good", 32'(oe), 1);
        chk("R7 byte unchanged", 32'(rd), 32'(ref_mem[1][8'h11]));

        // R8: fail during a write aborts it even if power returns first
        @(negedge clk);
        p0 = we_pulses;
        host_addr = 21'h180022; host_dq_i = 8'h99; host_oe_n = 1'b1;
        @(negedge clk); host_ce_n = 1'b0;
        @(negedge clk); host_we_n = 1'b0;
        repeat (4) @(negedge clk);
        pwr_fail = 1'b1;
        repeat (3) @(negedge clk);
        pwr_fail = 1'b0;
        repeat (8) @(negedge clk);
        host_we_n = 1'b1;
        @(negedge clk); host_ce_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        chk("R8 aborted write", 32'(we_pulses - p0), 0);
        do_read(21'h180022, rd, oe);
        chk("R8 byte unchanged", 32'(rd), 32'(ref_mem[3][8'h22]));

        // R9: data moving during a write is flagged and dropped
        @(negedge clk);
        p0 = we_pulses; e0 = err_pulses;
        host_addr = 21'h100033; host_dq_i = 8'h44; host_oe_n = 1'b1;
        @(negedge clk); host_ce_n = 1'b0;
        @(negedge clk); host_we_n = 1'b0;
        repeat (3) @(negedge clk);
        host_dq_i = 8'h45;
        repeat (3) @(negedge clk);
        host_we_n = 1'b1;
        @(negedge clk); host_ce_n = 1'b1;
        repeat (REC + 8) @(negedge clk);
        chk("R9 error pulse", 32'(err_pulses - e0), 1);
        chk("R9 no strobe", 32'(we_pulses - p0), 0);
        do_read(21'h100033, rd, oe);
        chk("R9 byte unchanged", 32'(rd), 32'(ref_mem[2][8'h33]));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule